// File: doc/BRIEF.md
# Rotating Register Rename Mapper

This block turns logical register numbers into physical slot numbers for three register files that each keep a rotating region: a general file, a one-bit predicate file and a floating-point file. Inside a file's rotating window every rotation renames register n to n+1, and the top register of the window wraps to the window's first register. Registers outside the window keep their own numbers. The general window starts at register 32, and its length is chosen at run time. The predicate window is registers 16 to 63. The floating-point window is registers 16 to 127.

The block keeps one rotation offset per file. A loop-branch rotation strobe moves every offset down by one in the same cycle, and a clear strobe sets them all back to zero. The mapping is purely combinational on the logical indices and the held offsets, so a register-file read port can place the mapper directly in front of its decoder. For the predicate file the block also drives the write that shifts the injected stage predicate into the slot about to wrap. The register arrays themselves live outside the block. All pins are plain control and index signals, because no data stream passes through the mapper.

Top module: `rrm_rotate_map`

## Requirements
- R1: After reset, every logical index of every file maps to the same physical index.
- R2: Let k be the number of rotations accepted since the last clear or reset. Inside a window that starts at B and holds S registers, logical L maps to B + ((L - B - k) mod S), with a non-negative modulo.
- R3: The general window covers registers 32 to 32+S-1, where S is the value on gr_rot_size. With S = 8 and one rotation accepted, logical 33 maps to 32 and logical 32 maps to 39.
- R4: General registers below 32 or at or above 32+S, predicate registers below 16, and floating-point registers below 16 each map to themselves.
- R5: The predicate window is fixed at registers 16 to 63 (S = 48), and the floating-point window is fixed at registers 16 to 127 (S = 112). Both follow the R2 rule.
- R6: A clear strobe returns all three offsets to zero on the next clock edge. This takes priority over a rotation strobe in the same cycle.
- R7: gr_rot_size = 0 disables general renaming, so every general index maps to itself. Values above 96 are treated as 96.
- R8: In a cycle where a rotation is accepted (rot_dec high and rot_clr low), pr_inj_we is 1, pr_inj_val equals stage_pred, and pr_inj_idx is the current physical slot of logical predicate 63. After that rotation, logical 16 maps to that same slot. In every other cycle pr_inj_we is 0.
- R9: The physical outputs follow the logical inputs in the same cycle. A rotation or clear changes the mapping only from the clock edge that samples the strobe onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rot_dec | input | 1 | Rotation strobe (base decrement) |
| rot_clr | input | 1 | Clear strobe, resets all rotation offsets |
| gr_rot_size | input | 7 | Number of rotating general registers, starting at register 32 |
| stage_pred | input | 1 | Stage predicate to shift into the predicate window |
| gr_log | input | 7 | Logical general register index |
| pr_log | input | 6 | Logical predicate register index |
| fr_log | input | 7 | Logical floating-point register index |
| gr_phys | output | 7 | Physical general register index |
| pr_phys | output | 6 | Physical predicate register index |
| fr_phys | output | 7 | Physical floating-point register index |
| pr_inj_we | output | 1 | Write strobe for the injected stage predicate |
| pr_inj_idx | output | 6 | Physical predicate slot that receives the injection |
| pr_inj_val | output | 1 | Injected predicate value |

## Verification
Several properties are checked by assertions on every cycle:
- registers below each window map to themselves;
- predicate indices inside the window stay inside it;
- a zero general size gives the identity mapping;
- the mapping is the identity right after a clear;
- the mapping holds steady while no strobe arrives;
- the injected slot reappears as logical 16 one rotation later.

The exact modular position after many rotations can only be shown by the bench's scenarios. These compare every cycle against a model that counts rotations. They also cover run-time changes of the general window size, the clamping of oversize windows, and the clear-over-rotate priority.

// File: rtl/rrm_pkg.sv
package rrm_pkg;
  localparam int GR_IDX_W_D  = 7;
  localparam int PR_IDX_W_D  = 6;
  localparam int FR_IDX_W_D  = 7;
  localparam int GR_BASE_D   = 32;
  localparam int PR_BASE_D   = 16;
  localparam int FR_BASE_D   = 16;

  typedef enum logic [1:0] {
    OFS_HOLD  = 2'd0,
    OFS_CLEAR = 2'd1,
    OFS_STEP  = 2'd2
  } ofs_cmd_e;
endpackage

// File: rtl/rrm_rot_offset.sv
module rrm_rot_offset #(
  parameter int W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  rrm_pkg::ofs_cmd_e   cmd,
  input  logic [W-1:0]        size,
  output logic [W-1:0]        off
);
  import rrm_pkg::*;

  logic [W-1:0] off_q, off_d;

  always_comb begin
    off_d = off_q;
    case (cmd)
      OFS_CLEAR: off_d = '0;
      OFS_STEP: begin
        if (size == '0)
          off_d = '0;
        else if (off_q == '0 || off_q >= size)
          off_d = size - W'(1);
        else
          off_d = off_q - W'(1);
      end
      default: off_d = off_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= '0;
    else        off_q <= off_d;
  end

  assign off = off_q;
endmodule

// File: rtl/rrm_window_map.sv
module rrm_window_map #(
  parameter int W    = 7,
  parameter int BASE = 32
) (
  input  logic [W-1:0] log_idx,
  input  logic [W-1:0] size,
  input  logic [W-1:0] off,
  output logic [W-1:0] phys_idx
);
  localparam logic [W-1:0] BASE_V = W'(BASE);

  logic [W-1:0] rel;
  logic [W:0]   sum;
  logic         in_win;
  logic         wrap;
  logic [W-1:0] red;

  always_comb begin
    rel      = log_idx - BASE_V;
    in_win   = (log_idx >= BASE_V) && (rel < size);
    sum      = {1'b0, rel} + {1'b0, off};
    wrap     = sum >= {1'b0, size};
    red      = wrap ? W'(sum - {1'b0, size}) : W'(sum);
    phys_idx = in_win ? (BASE_V + red) : log_idx;
  end
endmodule

// File: rtl/rrm_rotate_map.sv
module rrm_rotate_map #(
  parameter int GR_IDX_W = rrm_pkg::GR_IDX_W_D,
  parameter int PR_IDX_W = rrm_pkg::PR_IDX_W_D,
  parameter int FR_IDX_W = rrm_pkg::FR_IDX_W_D,
  parameter int GR_BASE  = rrm_pkg::GR_BASE_D,
  parameter int PR_BASE  = rrm_pkg::PR_BASE_D,
  parameter int FR_BASE  = rrm_pkg::FR_BASE_D
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rot_dec,
  input  logic                rot_clr,
  input  logic [GR_IDX_W-1:0] gr_rot_size,
  input  logic                stage_pred,
  input  logic [GR_IDX_W-1:0] gr_log,
  input  logic [PR_IDX_W-1:0] pr_log,
  input  logic [FR_IDX_W-1:0] fr_log,
  output logic [GR_IDX_W-1:0] gr_phys,
  output logic [PR_IDX_W-1:0] pr_phys,
  output logic [FR_IDX_W-1:0] fr_phys,
  output logic                pr_inj_we,
  output logic [PR_IDX_W-1:0] pr_inj_idx,
  output logic                pr_inj_val
);
  import rrm_pkg::*;

  localparam int GR_MAX_ROT = (1 << GR_IDX_W) - GR_BASE;
  localparam int PR_ROT_SZ  = (1 << PR_IDX_W) - PR_BASE;
  localparam int FR_ROT_SZ  = (1 << FR_IDX_W) - FR_BASE;
  localparam logic [GR_IDX_W-1:0] GR_MAX_V = GR_IDX_W'(GR_MAX_ROT);
  localparam logic [PR_IDX_W-1:0] PR_SZ_V  = PR_IDX_W'(PR_ROT_SZ);
  localparam logic [FR_IDX_W-1:0] FR_SZ_V  = FR_IDX_W'(FR_ROT_SZ);
  localparam logic [PR_IDX_W-1:0] PR_TOP_V = PR_IDX_W'((1 << PR_IDX_W) - 1);

  ofs_cmd_e              cmd;
  logic [GR_IDX_W-1:0]   gr_size_eff;
  logic [GR_IDX_W-1:0]   gr_off;
  logic [PR_IDX_W-1:0]   pr_off;
  logic [FR_IDX_W-1:0]   fr_off;

  always_comb begin
    if (rot_clr)      cmd = OFS_CLEAR;
    else if (rot_dec) cmd = OFS_STEP;
    else              cmd = OFS_HOLD;
  end

  assign gr_size_eff = (gr_rot_size > GR_MAX_V) ? GR_MAX_V : gr_rot_size;

  rrm_rot_offset #(.W(GR_IDX_W)) u_gr_ofs (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .size(gr_size_eff), .off(gr_off));
  rrm_rot_offset #(.W(PR_IDX_W)) u_pr_ofs (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .size(PR_SZ_V), .off(pr_off));
  rrm_rot_offset #(.W(FR_IDX_W)) u_fr_ofs (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .size(FR_SZ_V), .off(fr_off));

  rrm_window_map #(.W(GR_IDX_W), .BASE(GR_BASE)) u_gr_map (
    .log_idx(gr_log), .size(gr_size_eff), .off(gr_off), .phys_idx(gr_phys));
  rrm_window_map #(.W(PR_IDX_W), .BASE(PR_BASE)) u_pr_map (
    .log_idx(pr_log), .size(PR_SZ_V), .off(pr_off), .phys_idx(pr_phys));
  rrm_window_map #(.W(FR_IDX_W), .BASE(FR_BASE)) u_fr_map (
    .log_idx(fr_log), .size(FR_SZ_V), .off(fr_off), .phys_idx(fr_phys));

  // Slot that wraps on the next rotation: current home of the top predicate.
  rrm_window_map #(.W(PR_IDX_W), .BASE(PR_BASE)) u_inj_map (
    .log_idx(PR_TOP_V), .size(PR_SZ_V), .off(pr_off), .phys_idx(pr_inj_idx));

  assign pr_inj_we  = (cmd == OFS_STEP);
  assign pr_inj_val = stage_pred;
endmodule

// File: rtl/rrm_rotate_map_sva.sv
module rrm_rotate_map_sva #(
  parameter int GR_IDX_W = 7,
  parameter int PR_IDX_W = 6,
  parameter int FR_IDX_W = 7,
  parameter int GR_BASE  = 32,
  parameter int PR_BASE  = 16,
  parameter int FR_BASE  = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rot_dec,
  input logic                rot_clr,
  input logic [GR_IDX_W-1:0] gr_rot_size,
  input logic [GR_IDX_W-1:0] gr_log,
  input logic [PR_IDX_W-1:0] pr_log,
  input logic [FR_IDX_W-1:0] fr_log,
  input logic [GR_IDX_W-1:0] gr_phys,
  input logic [PR_IDX_W-1:0] pr_phys,
  input logic [FR_IDX_W-1:0] fr_phys,
  input logic [PR_IDX_W-1:0] pr_inj_idx
);
  localparam logic [GR_IDX_W-1:0] GB = GR_IDX_W'(GR_BASE);
  localparam logic [PR_IDX_W-1:0] PB = PR_IDX_W'(PR_BASE);
  localparam logic [FR_IDX_W-1:0] FB = FR_IDX_W'(FR_BASE);

  a_r4_gr_below: assert property (@(posedge clk) disable iff (!rst_n)
    gr_log < GB |-> gr_phys == gr_log);
  a_r4_pr_below: assert property (@(posedge clk) disable iff (!rst_n)
    pr_log < PB |-> pr_phys == pr_log);
  a_r4_fr_below: assert property (@(posedge clk) disable iff (!rst_n)
    fr_log < FB |-> fr_phys == fr_log);
  a_r5_pr_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    pr_log >= PB |-> pr_phys >= PB);
  a_r7_size_zero: assert property (@(posedge clk) disable iff (!rst_n)
    gr_rot_size == '0 |-> gr_phys == gr_log);
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rot_clr) |-> (gr_phys == gr_log && pr_phys == pr_log && fr_phys == fr_log));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rot_dec) && !$past(rot_clr) && $stable(fr_log)) |-> $stable(fr_phys));
  a_r8_inj_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rot_dec && !rot_clr) && pr_log == PB) |-> pr_phys == $past(pr_inj_idx));
  a_r8_inj_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    pr_inj_idx >= PB);
endmodule

bind rrm_rotate_map rrm_rotate_map_sva #(
  .GR_IDX_W(GR_IDX_W), .PR_IDX_W(PR_IDX_W), .FR_IDX_W(FR_IDX_W),
  .GR_BASE(GR_BASE), .PR_BASE(PR_BASE), .FR_BASE(FR_BASE)
) u_sva (
  .clk(clk), .rst_n(rst_n), .rot_dec(rot_dec), .rot_clr(rot_clr),
  .gr_rot_size(gr_rot_size), .gr_log(gr_log), .pr_log(pr_log), .fr_log(fr_log),
  .gr_phys(gr_phys), .pr_phys(pr_phys), .fr_phys(fr_phys), .pr_inj_idx(pr_inj_idx)
);

// File: tb/rrm_rotate_map_bench.sv
`timescale 1ns/1ps
module rrm_rotate_map_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rot_dec = 1'b0, rot_clr = 1'b0, stage_pred = 1'b0;
  logic [6:0] gr_rot_size = 7'd8;
  logic [6:0] gr_log = '0;
  logic [5:0] pr_log = '0;
  logic [6:0] fr_log = '0;
  logic [6:0] gr_phys;
  logic [5:0] pr_phys;
  logic [6:0] fr_phys;
  logic       pr_inj_we, pr_inj_val;
  logic [5:0] pr_inj_idx;

  int checks = 0;
  int errors = 0;
  int k_rot = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rrm_rotate_map u_rrm_rotate_map (
    .clk(clk), .rst_n(rst_n), .rot_dec(rot_dec), .rot_clr(rot_clr),
    .gr_rot_size(gr_rot_size), .stage_pred(stage_pred),
    .gr_log(gr_log), .pr_log(pr_log), .fr_log(fr_log),
    .gr_phys(gr_phys), .pr_phys(pr_phys), .fr_phys(fr_phys),
    .pr_inj_we(pr_inj_we), .pr_inj_idx(pr_inj_idx), .pr_inj_val(pr_inj_val));

  // Reference: rotations counted since clear/reset
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)       k_rot <= 0;
    else if (rot_clr) k_rot <= 0;
    else if (rot_dec) k_rot <= k_rot + 1;
  end

  function automatic int ref_map(int l, int b, int s, int k);
    if (s == 0 || l < b || l >= b + s) return l;
    return b + ((((l - b - k) % s) + s) % s);
  endfunction

  function automatic int gr_size_eff();
    return (int'(gr_rot_size) > 96) ? 96 : int'(gr_rot_size);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int s = gr_size_eff();
    bit in_gr = (int'(gr_log) >= 32) && (int'(gr_log) < 32 + s);
    chk(in_gr ? "R2 general" : "R4 general", int'(gr_phys), ref_map(int'(gr_log), 32, s, k_rot));
    chk("R5 predicate", int'(pr_phys), ref_map(int'(pr_log), 16, 48, k_rot));
    chk("R5 float", int'(fr_phys), ref_map(int'(fr_log), 16, 112, k_rot));
    chk("R8 inject we", int'(pr_inj_we), int'(rot_dec && !rot_clr));
    chk("R8 inject idx", int'(pr_inj_idx), ref_map(63, 16, 48, k_rot));
    chk("R8 inject val", int'(pr_inj_val), int'(stage_pred));
  endtask

  task automatic cyc();
    #2;
    compare_all();
    @(negedge clk);
    rot_dec = 1'b0;
    rot_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: identity after reset
    gr_log = 7'd35; pr_log = 6'd40; fr_log = 7'd100;
    #2;
    chk("R1 gr reset", int'(gr_phys), 35);
    chk("R1 pr reset", int'(pr_phys), 40);
    chk("R1 fr reset", int'(fr_phys), 100);
    @(negedge clk);
    // R3: one rotation with 8-register general window
    rot_dec = 1'b1; stage_pred = 1'b1;
    cyc();
    gr_log = 7'd33; #2;
    chk("R3 log33", int'(gr_phys), 32);
    gr_log = 7'd32; #2;
    chk("R3 log32", int'(gr_phys), 39);
    gr_log = 7'd40; #2;
    chk("R4 above top", int'(gr_phys), 40);
    // R9: mapping follows index in same cycle
    pr_log = 6'd16; #1;
    chk("R9 same cycle", int'(pr_phys), 63);
    @(negedge clk);
    // R6: clear beats rotate
    rot_dec = 1'b1; rot_clr = 1'b1; gr_log = 7'd34;
    cyc();
    chk("R6 clear wins", int'(gr_phys), 34);
    // R7: zero size, then oversize
    gr_rot_size = 7'd0;
    for (int i = 0; i < 5; i++) begin rot_dec = 1'b1; gr_log = 7'(33 + i); cyc(); end
    chk("R7 size zero", int'(gr_phys), int'(gr_log));
    rot_clr = 1'b1; cyc();
    gr_rot_size = 7'd127;
    for (int i = 0; i < 3; i++) begin rot_dec = 1'b1; cyc(); end
    gr_log = 7'd127; #2;
    chk("R7 clamp 96", int'(gr_phys), 124);
    @(negedge clk);
    // Random traffic against the reference model
    for (int i = 0; i < 400; i++) begin
      gr_log = 7'($urandom);
      pr_log = 6'($urandom);
      fr_log = 7'($urandom);
      stage_pred = 1'($urandom);
      rot_dec = ($urandom % 3) == 0;
      rot_clr = ($urandom % 25) == 0;
      if (rot_clr) begin
        cyc();
        case ($urandom % 5)
          0: gr_rot_size = 7'd0;
          1: gr_rot_size = 7'd5;
          2: gr_rot_size = 7'd8;
          3: gr_rot_size = 7'd96;
          default: gr_rot_size = 7'd110;
        endcase
      end else begin
        cyc();
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule